// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block decides when an 8-bit controller core must break off its program to service an interrupt, and which source it serves. Twelve request sources are sampled into a register on every clock, which is one instruction cycle here. The sample register is polled in the next cycle. The poll keeps only sources that have their own enable and the global enable set. It picks the winner by a two-bit level built from a low-priority bit and a high-priority bit; among sources at the same level, the lowest slot number wins. The core then receives a one-cycle call strobe and the number of the winning slot, which it turns into a service vector.

A call is held back while the core is not in the last cycle of its instruction, while it executes a return-from-interrupt or a write to an interrupt control register, and while a routine at the same or a higher level is still running. Running routines are tracked by a four-bit in-service stack with one bit per level. A call sets the bit of its level, and a return clears the highest set bit, so routines can nest.

Four external active-low pins each pass through a detector. The detector works edge-triggered or level-triggered, selected by a mode bit per pin. An edge flag clears when the call for its slot is issued. A level flag follows the pin.

Slot map, which is also the tie-break order:

| Slot | Source |
|------|--------|
| 0 | pin 0 |
| 1 | timer 0 |
| 2 | pin 1 |
| 3 | timer 1 |
| 4 | serial port |
| 5 | timer 2 (overflow or capture) |
| 6 | pin 2 |
| 7 | pin 3 |
| 8 | SPI done |
| 9 | keyboard wake |
| 10 | two-wire serial |
| 11 | USB |

Controller states:
- `ST_IDLE`: no eligible sample is waiting.
- `ST_WAIT`: an eligible sample could win but is blocked this cycle.
- `ST_CALL`: the one-cycle call strobe is being driven.

Transitions:
- idle→call, wait→call: unblocked winner.
- idle→wait: blocked winner.
- wait→idle: candidate gone.
- call→idle or call→wait: always leaves after one cycle.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `call_o` is 0 and `in_service_o` is 4'b0000.
- R2: A peripheral request that is high at clock edge E0 is captured at E0 and polled in the next cycle. If nothing blocks it, `call_o` is 1 for the cycle after E1, with `call_src_o` equal to its slot.
- R3: The level of slot s is {`prio_hi_i[s]`, `prio_lo_i[s]`}. The highest level wins, and equal levels go to the lowest slot number.
- R4: No call is issued from a poll cycle in which `last_i` is 0.
- R5: No call is issued from a poll cycle in which `reti_i` or `ctl_wr_i` is 1.
- R6: A call is issued only when the winner's level is strictly above the highest set bit of `in_service_o`. A higher level nests over a lower one.
- R7: A source takes part only when both its `src_en_i` bit and `glb_en_i` are 1.
- R8: With `pin_edge_i[k]`=1, a 1→0 transition on `pin_n_i[k]` sets a flag. The call for that pin's slot clears the flag, so one falling edge gives exactly one call even while the pin stays low. Pin k maps to slot 0, 2, 6, 7 for k = 0..3.
- R9: With `pin_edge_i[k]`=0, the flag equals the inverted pin, so a pin held low requests again after each return.
- R10: A call sets `in_service_o` bit equal to its level. A cycle with `reti_i`=1 clears the highest set bit.
- R11: Bits 0, 2, 6 and 7 of `periph_req_i` are ignored.
- R12: `call_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one instruction cycle per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_n_i | input | 4 | External interrupt pins, active low |
| pin_edge_i | input | 4 | Per-pin mode: 1 edge, 0 level |
| periph_req_i | input | 12 | Peripheral request flags by slot |
| src_en_i | input | 12 | Per-slot enable |
| glb_en_i | input | 1 | Global enable |
| prio_lo_i | input | 12 | Low priority bit per slot |
| prio_hi_i | input | 12 | High priority bit per slot |
| last_i | input | 1 | Core is in the final cycle of an instruction |
| reti_i | input | 1 | Core executes a return-from-interrupt |
| ctl_wr_i | input | 1 | Core writes an interrupt control register |
| call_o | output | 1 | One-cycle request to call a service vector |
| call_src_o | output | 4 | Slot of the call |
| in_service_o | output | 4 | In-service bit per level |

## Verification
The embedded assertions check the following on every cycle:
- each call came from a poll cycle that was the last of its instruction and was neither a return nor a control write;
- the call's level is the top of the in-service stack;
- a return removes exactly one level;
- call strobes never abut;
- an edge flag drops after its call.

Only the bench scenarios can show the rest. That covers the choice of winner among competing levels and slot ties, and the effect of each enable. It also covers one call per falling edge against repeated calls for a held level pin, nesting and unwinding, and the ignored pin slots of the peripheral vector. A behavioural model checks the call and stack outputs on every clock.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NUM_SRC = 12;
    localparam int NUM_PIN = 4;
    localparam int LVL_N   = 4;
    localparam int LVL_W   = $clog2(LVL_N);
    localparam int SRC_W   = $clog2(NUM_SRC);

    // slot of each external pin; slot order is also the tie-break order
    localparam int PIN_SLOT [NUM_PIN] = '{0, 2, 6, 7};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CALL = 2'd2
    } arb_state_e;

    function automatic logic [NUM_SRC-1:0] pin_slot_mask();
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_PIN; k++) begin
            m[PIN_SLOT[k]] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic flag_o
);

    logic pin_s_q;
    logic pin_d_q;
    logic flag_q;
    logic fall;

    assign fall = pin_d_q & ~pin_s_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_s_q <= 1'b1;
            pin_d_q <= 1'b1;
            flag_q  <= 1'b0;
        end else begin
            pin_s_q <= pin_n_i;
            pin_d_q <= pin_s_q;
            if (edge_mode_i) begin
                flag_q <= (flag_q & ~clr_i) | fall;
            end else begin
                flag_q <= ~pin_s_q;
            end
        end
    end

    assign flag_o = flag_q;

    // R8: a served edge flag drops unless a new edge arrives at once
    assert_edge_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && clr_i && !fall) |=> !flag_o);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 12,
    parameter int LVL_W   = 2,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] prio_lo_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    output logic               valid_o,
    output logic [SRC_W-1:0]   idx_o,
    output logic [LVL_W-1:0]   lvl_o
);

    logic [LVL_W-1:0] lvl_of [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
        assign lvl_of[s] = LVL_W'({prio_hi_i[s], prio_lo_i[s]});
    end

    // ascending scan with strict compare: lowest slot keeps a tie
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!valid_o || (lvl_of[i] > lvl_o))) begin
                valid_o = 1'b1;
                idx_o   = SRC_W'(i);
                lvl_o   = lvl_of[i];
            end
        end
    end

endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
    parameter int LVL_N  = 4,
    localparam int LVL_W = $clog2(LVL_N)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [LVL_N-1:0] isr_o,
    output logic             any_o,
    output logic [LVL_W-1:0] top_lvl_o
);

    logic [LVL_N-1:0] isr_q;
    logic [LVL_N-1:0] isr_d;

    always_comb begin
        top_lvl_o = '0;
        for (int l = 0; l < LVL_N; l++) begin
            if (isr_q[l]) begin
                top_lvl_o = LVL_W'(l);
            end
        end
    end

    assign any_o = |isr_q;

    always_comb begin
        isr_d = isr_q;
        if (pop_i && any_o) begin
            isr_d[top_lvl_o] = 1'b0;
        end
        if (push_i) begin
            isr_d[push_lvl_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            isr_q <= '0;
        end else begin
            isr_q <= isr_d;
        end
    end

    assign isr_o = isr_q;

    // R10: a return with a routine active removes exactly one level
    assert_pop_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && any_o) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_PIN-1:0] pin_n_i,
    input  logic [NUM_PIN-1:0] pin_edge_i,
    input  logic [NUM_SRC-1:0] periph_req_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               glb_en_i,
    input  logic [NUM_SRC-1:0] prio_lo_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    input  logic               last_i,
    input  logic               reti_i,
    input  logic               ctl_wr_i,
    output logic               call_o,
    output logic [SRC_W-1:0]   call_src_o,
    output logic [LVL_N-1:0]   in_service_o
);

    localparam logic [NUM_SRC-1:0] PIN_MASK = pin_slot_mask();

    arb_state_e         state_q, state_d;
    logic [NUM_PIN-1:0] pin_flag;
    logic [NUM_PIN-1:0] pin_clr;
    logic [NUM_SRC-1:0] src_flag;
    logic [NUM_SRC-1:0] sample_q;
    logic [NUM_SRC-1:0] eligible;
    logic               win_valid;
    logic [SRC_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;
    logic               svc_any;
    logic [LVL_W-1:0]   svc_top;
    logic               cand_ok;
    logic               unblocked;
    logic               go;
    logic [SRC_W-1:0]   src_q;
    logic [LVL_W-1:0]   call_lvl_q;

    // external pin detectors
    for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
        localparam int SLOT = PIN_SLOT[k];
        assign pin_clr[k] = go && (win_idx == SRC_W'(SLOT));
        irq_pin_detect u_det (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .pin_n_i     (pin_n_i[k]),
            .edge_mode_i (pin_edge_i[k]),
            .clr_i       (pin_clr[k]),
            .flag_o      (pin_flag[k])
        );
    end

    // merge pin flags into their slots
    always_comb begin
        src_flag = periph_req_i & ~PIN_MASK;
        for (int k = 0; k < NUM_PIN; k++) begin
            src_flag[PIN_SLOT[k]] = pin_flag[k];
        end
    end

    // sample stage: one snapshot per instruction cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sample_q <= '0;
        end else begin
            sample_q <= src_flag;
        end
    end

    // poll stage
    assign eligible = sample_q & src_en_i & {NUM_SRC{glb_en_i}};

    irq_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W)
    ) u_pick (
        .req_i     (eligible),
        .prio_lo_i (prio_lo_i),
        .prio_hi_i (prio_hi_i),
        .valid_o   (win_valid),
        .idx_o     (win_idx),
        .lvl_o     (win_lvl)
    );

    irq_svc_stack #(
        .LVL_N (LVL_N)
    ) u_stack (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (go),
        .push_lvl_i (win_lvl),
        .pop_i      (reti_i),
        .isr_o      (in_service_o),
        .any_o      (svc_any),
        .top_lvl_o  (svc_top)
    );

    assign cand_ok   = win_valid && (!svc_any || (win_lvl > svc_top));
    assign unblocked = last_i && !reti_i && !ctl_wr_i;
    assign go        = cand_ok && unblocked && (state_q != ST_CALL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                if (go) begin
                    state_d = ST_CALL;
                end else if (cand_ok) begin
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_CALL: begin
                state_d = cand_ok ? ST_WAIT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // call registers, loaded on a granted poll
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            src_q      <= '0;
            call_lvl_q <= '0;
        end else if (go) begin
            src_q      <= win_idx;
            call_lvl_q <= win_lvl;
        end
    end

    // outputs
    always_comb begin
        call_o     = 1'b0;
        call_src_o = src_q;
        unique case (state_q)
            ST_CALL:          call_o = 1'b1;
            ST_IDLE, ST_WAIT: call_o = 1'b0;
            default:          call_o = 1'b0;
        endcase
    end

    // R4: a call only follows a poll in the last instruction cycle
    assert_call_at_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        call_o |-> $past(last_i));

    // R5: a call never follows a return or a control write
    assert_call_not_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        call_o |-> $past(!reti_i && !ctl_wr_i));

    // R6: the level just called is the top of the in-service stack
    assert_call_top_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        call_o |-> ((in_service_o >> call_lvl_q) == LVL_N'(1)));

    // R12: call strobes never abut
    assert_call_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        call_o |=> !call_o);

endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  pin_n = 4'hF;
    logic [3:0]  pin_edge = 4'hF;
    logic [11:0] periph = '0;
    logic [11:0] src_en = '1;
    logic        glb_en = 1'b1;
    logic [11:0] prio_lo = '0;
    logic [11:0] prio_hi = '0;
    logic        last = 1'b1;
    logic        reti = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        call_o;
    logic [3:0]  call_src_o;
    logic [3:0]  in_service_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_arbiter u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .pin_n_i      (pin_n),
        .pin_edge_i   (pin_edge),
        .periph_req_i (periph),
        .src_en_i     (src_en),
        .glb_en_i     (glb_en),
        .prio_lo_i    (prio_lo),
        .prio_hi_i    (prio_hi),
        .last_i       (last),
        .reti_i       (reti),
        .ctl_wr_i     (ctl_wr),
        .call_o       (call_o),
        .call_src_o   (call_src_o),
        .in_service_o (in_service_o)
    );

    // ---------------- behavioural reference model ----------------
    int slots [4] = '{0, 2, 6, 7};
    bit m_ps [4] = '{1, 1, 1, 1};
    bit m_pd [4] = '{1, 1, 1, 1};
    bit m_flag [4] = '{0, 0, 0, 0};
    bit m_samp [12];
    bit m_isr [4] = '{0, 0, 0, 0};
    bit m_incall = 0;
    int m_src = 0;

    always @(posedge clk) begin
        int best, blvl, cur, lv;
        bit go;
        bit nf [4];
        if (!rst_ni) begin
            for (int k = 0; k < 4; k++) begin
                m_ps[k] = 1; m_pd[k] = 1; m_flag[k] = 0; m_isr[k] = 0;
            end
            for (int i = 0; i < 12; i++) m_samp[i] = 0;
            m_incall = 0;
            m_src = 0;
        end else begin
            best = -1; blvl = -1;
            for (int i = 0; i < 12; i++) begin
                if (m_samp[i] && src_en[i] && glb_en) begin
                    lv = 2 * int'(prio_hi[i]) + int'(prio_lo[i]);
                    if (lv > blvl) begin best = i; blvl = lv; end
                end
            end
            cur = -1;
            for (int l = 0; l < 4; l++) if (m_isr[l]) cur = l;
            go = (best >= 0) && (blvl > cur) && !m_incall && last && !reti && !ctl_wr;
            for (int k = 0; k < 4; k++) begin
                if (pin_edge[k])
                    nf[k] = (m_flag[k] && !(go && best == slots[k])) || (m_pd[k] && !m_ps[k]);
                else
                    nf[k] = !m_ps[k];
            end
            for (int i = 0; i < 12; i++) m_samp[i] = periph[i];
            for (int k = 0; k < 4; k++) m_samp[slots[k]] = m_flag[k];
            for (int k = 0; k < 4; k++) begin
                m_pd[k] = m_ps[k]; m_ps[k] = pin_n[k]; m_flag[k] = nf[k];
            end
            if (reti && cur >= 0) m_isr[cur] = 0;
            if (go) m_isr[blvl] = 1;
            m_incall = go;
            if (go) m_src = best;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_ni && !done) begin
            int misr;
            misr = 0;
            for (int l = 0; l < 4; l++) if (m_isr[l]) misr |= (1 << l);
            chk("R2 model call", int'(call_o), int'(m_incall));
            if (m_incall) chk("R3 model slot", int'(call_src_o), m_src);
            chk("R10 model stack", int'(in_service_o), misr);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected 0 cycles over limit", cyc);
            finish_run();
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wait_call(int maxc, output int src);
        src = -1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (call_o) begin src = int'(call_src_o); break; end
        end
    endtask

    task automatic quiet(int n, string req);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (call_o) seen++;
        end
        chk(req, seen, 0);
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int s;
        idle(3);
        chk("R1 call after reset", int'(call_o), 0);
        chk("R1 stack after reset", int'(in_service_o), 0);
        rst_ni = 1'b1;
        idle(2);

        // R2: latency and pulse
        periph[1] = 1'b1;
        @(negedge clk);
        chk("R2 no call one cycle after request", int'(call_o), 0);
        @(negedge clk);
        chk("R2 call two cycles after request", int'(call_o), 1);
        chk("R2 call slot", int'(call_src_o), 1);
        periph[1] = 1'b0;
        @(negedge clk);
        chk("R12 strobe is one cycle", int'(call_o), 0);
        chk("R10 level 0 in service", int'(in_service_o), 1);
        do_reti();
        chk("R10 return clears stack", int'(in_service_o), 0);
        idle(2);

        // R3: highest level wins, R6: lower level waits
        prio_hi[9] = 1'b1;
        periph[3] = 1'b1; periph[9] = 1'b1;
        wait_call(10, s);
        chk("R3 level 2 beats level 0", s, 9);
        periph[9] = 1'b0;
        quiet(6, "R6 lower level blocked while higher in service");
        do_reti();
        wait_call(10, s);
        chk("R6 lower level after return", s, 3);
        periph[3] = 1'b0;
        do_reti();
        prio_hi[9] = 1'b0;
        idle(2);

        // R3: tie goes to lowest slot
        prio_lo[4] = 1'b1; prio_lo[8] = 1'b1;
        periph[4] = 1'b1; periph[8] = 1'b1;
        wait_call(10, s);
        chk("R3 tie lowest slot", s, 4);
        periph[4] = 1'b0;
        do_reti();
        wait_call(10, s);
        chk("R3 tie second slot", s, 8);
        periph[8] = 1'b0;
        do_reti();
        prio_lo = '0;
        idle(2);

        // R4: instruction boundary
        last = 1'b0;
        periph[5] = 1'b1;
        quiet(6, "R4 no call mid-instruction");
        last = 1'b1;
        wait_call(10, s);
        chk("R4 call at boundary", s, 5);
        periph[5] = 1'b0;
        do_reti();
        idle(2);

        // R5: control write and return block
        ctl_wr = 1'b1;
        periph[5] = 1'b1;
        quiet(6, "R5 no call during control write");
        ctl_wr = 1'b0;
        wait_call(10, s);
        chk("R5 call after write", s, 5);
        periph[5] = 1'b0;
        do_reti();
        idle(2);
        reti = 1'b1;
        periph[5] = 1'b1;
        quiet(6, "R5 no call during return");
        reti = 1'b0;
        wait_call(10, s);
        chk("R5 call after return ends", s, 5);
        periph[5] = 1'b0;
        do_reti();
        idle(2);

        // R7: enables
        src_en[5] = 1'b0;
        periph[5] = 1'b1;
        quiet(6, "R7 source disabled");
        src_en[5] = 1'b1;
        glb_en = 1'b0;
        quiet(6, "R7 global disabled");
        glb_en = 1'b1;
        wait_call(10, s);
        chk("R7 call when both enabled", s, 5);
        periph[5] = 1'b0;
        do_reti();
        idle(2);

        // R8: edge pin 1 -> slot 2, one call per edge
        pin_n[1] = 1'b0;
        wait_call(10, s);
        chk("R8 edge pin call", s, 2);
        do_reti();
        quiet(8, "R8 held pin gives no second call");
        pin_n[1] = 1'b1;
        idle(3);

        // R9: level pin 2 -> slot 6, repeats while low
        pin_edge[2] = 1'b0;
        pin_n[2] = 1'b0;
        wait_call(10, s);
        chk("R9 level pin call", s, 6);
        do_reti();
        wait_call(10, s);
        chk("R9 level pin calls again", s, 6);
        pin_n[2] = 1'b1;
        idle(4);
        do_reti();
        quiet(8, "R9 released level pin quiet");
        pin_edge[2] = 1'b1;

        // R11: pin slots of peripheral vector ignored
        periph[0] = 1'b1; periph[6] = 1'b1;
        quiet(8, "R11 pin slots ignored");
        periph[0] = 1'b0; periph[6] = 1'b0;
        idle(2);

        // R6/R10: nesting
        periph[11] = 1'b1;
        wait_call(10, s);
        chk("R6 base call", s, 11);
        periph[11] = 1'b0;
        prio_lo[10] = 1'b1; prio_hi[10] = 1'b1;
        periph[10] = 1'b1;
        wait_call(10, s);
        chk("R6 higher level nests", s, 10);
        periph[10] = 1'b0;
        @(negedge clk);
        chk("R10 two levels in service", int'(in_service_o), 9);
        do_reti();
        chk("R10 return pops top level", int'(in_service_o), 1);
        do_reti();
        chk("R10 second return empties", int'(in_service_o), 0);
        idle(4);

        finish_run();
    end

endmodule